// File: doc/BRIEF.md
# Sign-Magnitude Ladder DAC Serializer

This block feeds an external two-rail resistor-ladder converter. The ladder is switched by chains of 8-bit shift registers with output latches, and there is one chain for each polarity. The block accepts one signed 28-bit PCM sample per audio frame and splits it into a sign and a 27-bit magnitude. It shifts the magnitude serially into the chains on a bit clock. The rising edge of the frame clock then transfers the shifted word into the latches. Two complementary bank enables select which polarity's chain drives the ladder.

All timing comes from one counter on the master clock. A frame has 64 bit-clock periods, and each period lasts `2*HALF_DIV` master cycles. The first 32 periods carry zeros while the frame clock is high. The last 32 periods carry the 32-bit chain word while the frame clock is low. That word is five zero pad bits followed by the magnitude, MSB first. Samples arrive over a valid/ready handshake. Ready is offered for exactly one master cycle per frame, which is the last cycle before the latch edge. A producer raises valid and holds the sample stable until it sees valid and ready high in the same cycle. Back-pressure is therefore at most one frame long. A frame in which no sample is accepted shifts a zero magnitude and keeps the previous sign.

The polarity of a sample is applied on the same frame-clock edge that latches its magnitude. As a result, the enables switch only when the sign changes, at a zero crossing.

Top module: `sm_ladder_serializer`

## Requirements
- R1: A sample with bit 27 clear selects the positive bank, and its magnitude equals its value. A sample with bit 27 set selects the negative bank, and its magnitude equals the negated value.
- R2: The input -2^27 is saturated to magnitude 2^27-1 and selects the negative bank.
- R3: Each frame carries 64 serial slots. Slots 0-31 carry 0. Slots 32-36 carry 0 as padding. Slots 37-63 carry magnitude bits 26 down to 0, MSB first.
- R4: `bclk_o` is low for the first `HALF_DIV` master cycles of each slot and high for the rest. `sdata_o` changes only on a falling edge of `bclk_o`.
- R5: `lrclk_o` is high during slots 0-31 and low during slots 32-63. It rises at the start of slot 0, which is also a falling edge of `bclk_o`.
- R6: `en_neg_o` is always the inverse of `en_pos_o`.
- R7: The enables change only on a rising edge of `lrclk_o`. On that edge they take the sign of the word shifted in the frame that just ended (`en_neg_o`=1 for negative).
- R8: `in_ready` is high only in the last master cycle of a frame. A sample is accepted when `in_valid` and `in_ready` are both high, and it is shifted out in the following frame.
- R9: If no sample is accepted at a frame boundary, the next frame shifts zero magnitude and the enables keep their state.
- R10: In reset, `bclk_o`=0, `lrclk_o`=1, `sdata_o`=0, `en_pos_o`=1, `en_neg_o`=0 and `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted this cycle if valid |
| in_sample | input | 28 | Signed two's-complement sample |
| bclk_o | output | 1 | Bit (shift) clock |
| sdata_o | output | 1 | Serial data, changes on falling bit clock |
| lrclk_o | output | 1 | Frame clock; rising edge latches the chains |
| en_pos_o | output | 1 | Positive bank enable |
| en_neg_o | output | 1 | Negative bank enable |

## Verification
The hardest situations to reach are the frames in which the sign flips, or in which no sample arrives, because the enables must then hold or switch exactly on the latch edge. The stimulus alternates signs across consecutive frames, inserts empty frames after both positive and negative samples, and includes the saturating most-negative input. A behavioural model tracks every master cycle. At each rising edge of the frame clock, the bench also rebuilds the word it captured on the bit-clock rising edges and compares it with a queue of expected words.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic {
    BANK_POS = 1'b0,
    BANK_NEG = 1'b1
  } bank_e;
endpackage

// File: rtl/sdac_frame_timer.sv
module sdac_frame_timer #(
  parameter int HALF_DIV = 2,
  parameter int SLOTS = 64,
  localparam int BIT_P = 2 * HALF_DIV,
  localparam int FRAME_LEN = SLOTS * BIT_P,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_last,
  output logic             bclk_q,
  output logic             lrclk_q
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    frame_last = (cnt_q == CNT_W'(FRAME_LEN - 1));
    cnt_nxt = frame_last ? '0 : cnt_q + 1'b1;
  end

  // The outputs are registered from the next count, so bclk and lrclk come
  // straight off flops with no gating in their paths.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      bclk_q  <= (int'(cnt_nxt) % BIT_P) >= HALF_DIV;
      lrclk_q <= (int'(cnt_nxt) / BIT_P) < (SLOTS / 2);
    end
  end

  // R4: every slot starts with bclk low
  assert_slot_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> !bclk_q);
endmodule

// File: rtl/sdac_sm_convert.sv
module sdac_sm_convert #(
  parameter int SAMPLE_W = 28,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                neg,
  output logic [MAG_W-1:0]    mag
);
  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    neg = sample[SAMPLE_W-1];
    negated = -sample;
    if (!neg) begin
      mag = sample[MAG_W-1:0];
    end else if (negated[SAMPLE_W-1]) begin
      mag = '1;
    end else begin
      mag = negated[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/sdac_bit_serializer.sv
module sdac_bit_serializer #(
  parameter int MAG_W = 27,
  parameter int CHAIN_W = 32,
  parameter int SLOTS = 64,
  parameter int BIT_P = 4,
  parameter int CNT_W = 8,
  localparam int PAD_W = CHAIN_W - MAG_W,
  localparam int IDX_W = $clog2(CHAIN_W),
  localparam int FIRST_WORD_SLOT = SLOTS - CHAIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [MAG_W-1:0] mag,
  output logic             sdata_q
);
  logic [CHAIN_W-1:0] word;
  logic [IDX_W-1:0]   idx;
  logic               in_word;
  logic               bit_nxt;
  int                 slot;

  always_comb begin
    word    = {{PAD_W{1'b0}}, mag};
    slot    = int'(cnt_nxt) / BIT_P;
    in_word = slot >= FIRST_WORD_SLOT;
    idx     = IDX_W'(CHAIN_W - 1 - (slot - FIRST_WORD_SLOT));
    bit_nxt = in_word ? word[idx] : 1'b0;
  end

  // The slot changes only when a new bit period starts, so the data moves
  // together with the falling bit clock.
  always_ff @(posedge clk) begin
    if (!rst_n) sdata_q <= 1'b0;
    else        sdata_q <= bit_nxt;
  end
endmodule

// File: rtl/sm_ladder_serializer.sv
module sm_ladder_serializer #(
  parameter int SAMPLE_W = 28,
  parameter int STAGE_W = 8,
  parameter int STAGES = 4,
  parameter int SLOTS = 64,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                bclk_o,
  output logic                sdata_o,
  output logic                lrclk_o,
  output logic                en_pos_o,
  output logic                en_neg_o
);
  import sdac_pkg::*;

  localparam int MAG_W = SAMPLE_W - 1;
  localparam int CHAIN_W = STAGE_W * STAGES;
  localparam int BIT_P = 2 * HALF_DIV;
  localparam int FRAME_LEN = SLOTS * BIT_P;
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] cnt_nxt;
  logic             frame_last;
  logic             s_neg;
  logic [MAG_W-1:0] s_mag;
  logic [MAG_W-1:0] cur_mag;
  bank_e            cur_bank;
  logic             en_pos_q;
  logic             en_neg_q;

  sdac_frame_timer #(.HALF_DIV(HALF_DIV), .SLOTS(SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .frame_last(frame_last),
    .bclk_q(bclk_o), .lrclk_q(lrclk_o)
  );

  sdac_sm_convert #(.SAMPLE_W(SAMPLE_W)) u_conv (
    .sample(in_sample), .neg(s_neg), .mag(s_mag)
  );

  sdac_bit_serializer #(
    .MAG_W(MAG_W), .CHAIN_W(CHAIN_W), .SLOTS(SLOTS), .BIT_P(BIT_P), .CNT_W(CNT_W)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .mag(cur_mag), .sdata_q(sdata_o)
  );

  assign in_ready = frame_last;

  // At the frame boundary the bank of the word just shifted is applied and the
  // next word is loaded in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mag  <= '0;
      cur_bank <= BANK_POS;
      en_pos_q <= 1'b1;
      en_neg_q <= 1'b0;
    end else if (frame_last) begin
      en_pos_q <= (cur_bank == BANK_POS);
      en_neg_q <= (cur_bank == BANK_NEG);
      if (in_valid) begin
        cur_mag  <= s_mag;
        cur_bank <= s_neg ? BANK_NEG : BANK_POS;
      end else begin
        cur_mag <= '0;
      end
    end
  end

  assign en_pos_o = en_pos_q;
  assign en_neg_o = en_neg_q;

  assert_en_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_pos_q != en_neg_q);
  assert_en_on_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_pos_q) |-> $rose(lrclk_o));
  assert_sdata_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_o));
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lrclk_o |-> !sdata_o);
  assert_ready_before_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $rose(lrclk_o));
  assert_latch_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrclk_o) |-> !bclk_o);
endmodule

// File: tb/sm_ladder_serializer_bench.sv
module sm_ladder_serializer_bench;
  localparam int HALF = 2;
  localparam int BITP = 2 * HALF;
  localparam int NSLOT = 64;
  localparam int FRAME = NSLOT * BITP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [27:0] in_sample = '0;
  logic bclk_o, sdata_o, lrclk_o, en_pos_o, en_neg_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sm_ladder_serializer u_sm_ladder_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .bclk_o(bclk_o), .sdata_o(sdata_o),
    .lrclk_o(lrclk_o), .en_pos_o(en_pos_o), .en_neg_o(en_neg_o)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [26:0] sat_mag(input logic [27:0] s);
    longint v;
    v = longint'($signed(s));
    if (v == -(longint'(1) << 27)) return 27'h7ffffff;
    if (v < 0) return 27'(-v);
    return 27'(v);
  endfunction

  // reference model
  int m_cnt = 0;
  logic [26:0] m_mag = '0;
  bit m_sign = 0;
  bit m_bank = 0;
  logic [31:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mag = '0; m_sign = 0; m_bank = 0;
      exp_q.delete();
      exp_q.push_back(32'h0);
    end else begin
      if (m_cnt == FRAME - 1) begin
        m_bank = m_sign;
        if (in_valid) begin
          m_mag = sat_mag(in_sample);
          m_sign = in_sample[27];
        end else begin
          m_mag = '0;
        end
        exp_q.push_back({5'b0, m_mag});
      end
      m_cnt = (m_cnt + 1) % FRAME;
    end
  end

  // monitor
  logic prev_bclk = 1'b0;
  logic prev_lr = 1'b1;
  logic [31:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int slot;
      int idx;
      logic e_sd;
      slot = m_cnt / BITP;
      idx = NSLOT - 1 - slot;
      e_sd = (slot >= NSLOT - 32 && idx < 27) ? m_mag[idx] : 1'b0;
      chk(bclk_o == ((m_cnt % BITP) >= HALF), "R4 bclk", bclk_o, (m_cnt % BITP) >= HALF);
      chk(lrclk_o == (slot < NSLOT / 2), "R5 lrclk", lrclk_o, slot < NSLOT / 2);
      chk(sdata_o == e_sd, "R3 sdata", sdata_o, e_sd);
      chk(en_pos_o == !m_bank, "R7 en_pos", en_pos_o, !m_bank);
      chk(en_neg_o == m_bank, "R6 en_neg", en_neg_o, m_bank);
      chk(in_ready == (m_cnt == FRAME - 1), "R8 in_ready", in_ready, m_cnt == FRAME - 1);
      if (bclk_o && !prev_bclk) cap = {cap[30:0], sdata_o};
      if (lrclk_o && !prev_lr) begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cap == e, "R1 R2 R9 R3 frame word", cap, e);
      end
      prev_bclk = bclk_o;
      prev_lr = lrclk_o;
    end
  end

  task automatic send(input int s);
    in_sample = 28'(s);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gap();
    repeat (FRAME + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(bclk_o == 1'b0, "R10 bclk", bclk_o, 0);
    chk(lrclk_o == 1'b1, "R10 lrclk", lrclk_o, 1);
    chk(sdata_o == 1'b0, "R10 sdata", sdata_o, 0);
    chk(en_pos_o == 1'b1, "R10 en_pos", en_pos_o, 1);
    chk(en_neg_o == 1'b0, "R10 en_neg", en_neg_o, 0);
    chk(in_ready == 1'b0, "R10 in_ready", in_ready, 0);
    rst_n = 1'b1;
    send(100);
    send(-100);
    send(-(1 << 27));
    send((1 << 27) - 1);
    gap();
    send(-1);
    gap();
    gap();
    send(0);
    send(5);
    send(-7);
    send(-(1 << 26));
    send(12345678);
    gap();
    gap();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule